// File: doc/BRIEF.md
# Fuse-Configured Sum-of-Products Plane

This block models the programmable AND-OR plane of a small array-logic device. It takes twelve dedicated inputs and ten feedback signals from the output stage. It turns each of the 22 signals into a true column and an inverted column. From those 44 columns it forms every product-term row, and it ORs a different number of rows into each of ten sums. Beside the sums it gives one enable term for each output and two global register-control terms: an asynchronous clear and a synchronous set. It also passes out the two configuration bits of each output cell. The output cells themselves are not part of this block.

The configuration is a chain of fuse bits, one bit per fuse, loaded serially. A 1 marks a blown fuse and a 0 an intact one. An intact fuse connects its column into the AND of its row. A serial read-back shows the fuses without disturbing them. The last fuse is a lock: once it is set, every bit read back appears blown.

Each output gets its own number of product terms. From the outer outputs to the middle ones the count rises in steps of two and then falls again. The array therefore spends its rows where the middle outputs need them.

Top module: `fuse_sop_plane`

## Requirements
- R1: A clock edge with `rst_n` low leaves every fuse intact (0) and the lock clear. After that, every term output is 0 for any input, `mc_cfg` is 0 and `cfg_sdo` is 0.
- R2: While `cfg_load_en` is high, each clock edge shifts `cfg_sdi` into the chain. In a load of 5829 edges, the bit presented at edge k (counting from 0) ends up in fuse k, so the lowest-numbered fuse is sent first. A 1 means blown and a 0 means intact.
- R3: Array input k is `ded_in[k]` for k < 12 and `fb_in[k-12]` otherwise. Column 2k is its true value and column 2k+1 its inverse. Row r uses fuses 44*r to 44*r+43, where column c maps to fuse 44*r+c. The row term is the AND of every column whose fuse is intact. A row with all fuses intact gives 0, and a row with all fuses blown gives 1.
- R4: Row 0 drives `ar_term` and row 131 drives `ss_term`. Output o owns a block of rows that starts at row 1 plus the sum of (T(p)+1) over all p < o. The first row of that block drives `oe_term[o]`, and the next T(o) rows are ORed into `sum_out[o]`. T for outputs 0 to 9 is 8, 10, 12, 14, 16, 16, 14, 12, 10, 8.
- R5: `mc_cfg[2o]` shows fuse 5808+2o and `mc_cfg[2o+1]` shows fuse 5809+2o.
- R6: While `cfg_rd_en` is high and `cfg_load_en` is low, `cfg_sdo` shows fuse 0 first and moves on by one fuse at each edge. After 5828 edges the configuration is back in its original state.
- R7: Fuse 5828 is the lock. When it is blown, `cfg_sdo` reads 1 throughout a read-back, and the array still computes as it does with the lock clear.
- R8: With both enables low, the configuration does not change: `mc_cfg`, the lock and the array function are all held.
- R9: While either enable is high, `sum_out`, `oe_term`, `ar_term` and `ss_term` are all forced to 0.
- R10: The term outputs follow `ded_in` and `fb_in` through logic only, with no clock edge in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Synchronous active-low reset, leaves all fuses intact |
| ded_in | input | 12 | Dedicated array inputs |
| fb_in | input | 10 | Feedback inputs from the output stage |
| cfg_load_en | input | 1 | Shift the chain from `cfg_sdi` |
| cfg_rd_en | input | 1 | Rotate the chain for read-back |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sdo | output | 1 | Serial read-back data, forced to 1 when locked |
| sum_out | output | 10 | OR of each output's product terms |
| oe_term | output | 10 | Per-output enable product term |
| ar_term | output | 1 | Global asynchronous-clear product term |
| ss_term | output | 1 | Global synchronous-set product term |
| mc_cfg | output | 20 | Two configuration fuses per output cell |

## Verification
A fuse that lands at the wrong place in the chain shows up at once. The sum or enable term that uses that fuse takes the wrong value on the first input vector where its column matters. The same fault also appears in the bit order of a read-back. Off-by-one errors in the row blocks are caught by images that blow only the first and last rows of a block. The error then shows on a neighbouring output in the same cycle the inputs are applied. If read-back failed to restore the chain, the sums would be wrong right after the 5828th rotate edge. A lock that leaks through would show as a 0 on `cfg_sdo` during a locked read.

// File: rtl/fsp_pkg.sv
// Package: geometry helpers for the sum-of-products plane.
// Assumes outputs are numbered from the edge toward the middle and back,
// so term counts are symmetric about the centre.
package fsp_pkg;

    // Number of summed product terms owned by output o.
    function automatic int terms_of(int o, int n_out, int t_min, int t_step);
        int k;
        k = (o < n_out / 2) ? o : (n_out - 1 - o);
        return t_min + t_step * k;
    endfunction

    // First row (the enable row) of output o's block; row 0 is the clear row.
    function automatic int block_base(int o, int n_out, int t_min, int t_step);
        int b;
        b = 1;
        for (int p = 0; p < o; p++) begin
            b += terms_of(p, n_out, t_min, t_step) + 1;
        end
        return b;
    endfunction

    // Total rows: clear row, all output blocks, set row.
    function automatic int total_rows(int n_out, int t_min, int t_step);
        return block_base(n_out, n_out, t_min, t_step) + 1;
    endfunction

endpackage

// File: rtl/fsp_fuse_chain.sv
// Module: serial fuse chain with a separate lock bit.
// Load shifts lock and chain together, with the lowest fuse sent first.
// Read rotates only the chain, so the image comes back after CHAIN_LEN edges.
// Assumes load has priority over read.
module fsp_fuse_chain #(
    parameter int CHAIN_LEN = 5828
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic                 rd_en,
    input  logic                 sdi,
    output logic [CHAIN_LEN-1:0] chain_q,
    output logic                 lock_q,
    output logic                 sdo
);

    // Shift in on load, rotate on read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            lock_q  <= 1'b0;
        end else if (load_en) begin
            lock_q  <= sdi;
            chain_q <= {lock_q, chain_q[CHAIN_LEN-1:1]};
        end else if (rd_en) begin
            chain_q <= {chain_q[0], chain_q[CHAIN_LEN-1:1]};
        end
    end

    // A set lock makes every fuse read as blown.
    assign sdo = lock_q | chain_q[0];

endmodule

// File: rtl/fsp_term_row.sv
// Module: one product-term row.
// An intact fuse (0) connects its column into the AND; a blown one (1) drops it.
module fsp_term_row #(
    parameter int N_COL = 44
) (
    input  logic [N_COL-1:0] cols,
    input  logic [N_COL-1:0] fuses,
    output logic             term
);

    // Row AND over the connected columns.
    assign term = &(fuses | cols);

endmodule

// File: rtl/fsp_sum_select.sv
// Module: groups product rows into enable, sum and global control terms,
// and gates everything to 0 while the configuration is moving.
// Assumes rows are ordered: clear, then per-output blocks, then set.
module fsp_sum_select #(
    parameter int N_OUT  = 10,
    parameter int T_MIN  = 8,
    parameter int T_STEP = 2,
    parameter int N_ROWS = fsp_pkg::total_rows(N_OUT, T_MIN, T_STEP)
) (
    input  logic [N_ROWS-1:0] pt,
    input  logic              busy,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  oe_term,
    output logic              ar_term,
    output logic              ss_term
);

    logic [N_OUT-1:0] sum_raw;
    logic [N_OUT-1:0] oe_raw;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int BASE = fsp_pkg::block_base(o, N_OUT, T_MIN, T_STEP);
        localparam int NT   = fsp_pkg::terms_of(o, N_OUT, T_MIN, T_STEP);
        // Enable row leads the block, summed rows follow it.
        assign oe_raw[o]  = pt[BASE];
        assign sum_raw[o] = |pt[BASE+1 +: NT];
    end

    // Hold all terms low while the chain shifts or rotates.
    always_comb begin
        sum_out = busy ? '0 : sum_raw;
        oe_term = busy ? '0 : oe_raw;
        ar_term = !busy && pt[0];
        ss_term = !busy && pt[N_ROWS-1];
    end

endmodule

// File: rtl/fuse_sop_plane.sv
// Module: top of the fuse-configured sum-of-products plane.
// Builds true/inverted columns from dedicated and feedback inputs, evaluates
// every row against the fuse chain, and selects sums, enables and controls.
// Assumes cfg_sdi/enables are synchronous to clk; term paths are combinational.
module fuse_sop_plane #(
    parameter int N_DED  = 12,
    parameter int N_OUT  = 10,
    parameter int T_MIN  = 8,
    parameter int T_STEP = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_DED-1:0]     ded_in,
    input  logic [N_OUT-1:0]     fb_in,
    input  logic                 cfg_load_en,
    input  logic                 cfg_rd_en,
    input  logic                 cfg_sdi,
    output logic                 cfg_sdo,
    output logic [N_OUT-1:0]     sum_out,
    output logic [N_OUT-1:0]     oe_term,
    output logic                 ar_term,
    output logic                 ss_term,
    output logic [2*N_OUT-1:0]   mc_cfg
);

    localparam int N_IN        = N_DED + N_OUT;
    localparam int N_COL       = 2 * N_IN;
    localparam int N_ROWS      = fsp_pkg::total_rows(N_OUT, T_MIN, T_STEP);
    localparam int ARRAY_FUSES = N_ROWS * N_COL;
    localparam int CFG_FUSES   = 2 * N_OUT;
    localparam int CHAIN_LEN   = ARRAY_FUSES + CFG_FUSES;

    logic [N_IN-1:0]      in_vec;
    logic [N_COL-1:0]     cols;
    logic [CHAIN_LEN-1:0] chain_q;
    logic                 lock_q;
    logic [N_ROWS-1:0]    pt;
    logic                 busy;

    // Array input order: dedicated inputs low, feedback above.
    assign in_vec = {fb_in, ded_in};
    assign busy   = cfg_load_en | cfg_rd_en;

    for (genvar k = 0; k < N_IN; k++) begin : g_col
        // Even column true, odd column inverted.
        assign cols[2*k]   = in_vec[k];
        assign cols[2*k+1] = ~in_vec[k];
    end

    fsp_fuse_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (cfg_load_en),
        .rd_en   (cfg_rd_en),
        .sdi     (cfg_sdi),
        .chain_q (chain_q),
        .lock_q  (lock_q),
        .sdo     (cfg_sdo)
    );

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        fsp_term_row #(.N_COL(N_COL)) u_row (
            .cols  (cols),
            .fuses (chain_q[r*N_COL +: N_COL]),
            .term  (pt[r])
        );
    end

    fsp_sum_select #(
        .N_OUT  (N_OUT),
        .T_MIN  (T_MIN),
        .T_STEP (T_STEP),
        .N_ROWS (N_ROWS)
    ) u_sel (
        .pt      (pt),
        .busy    (busy),
        .sum_out (sum_out),
        .oe_term (oe_term),
        .ar_term (ar_term),
        .ss_term (ss_term)
    );

    // Per-output cell configuration pairs sit right after the array.
    assign mc_cfg = chain_q[ARRAY_FUSES +: CFG_FUSES];

endmodule

// File: rtl/fuse_sop_plane_chk.sv
// Module: property checker for fuse_sop_plane, attached with bind.
// Assumes it sees the top's lock state through the bind connection.
module fuse_sop_plane_chk #(
    parameter int N_OUT = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_load_en,
    input logic               cfg_rd_en,
    input logic [N_OUT-1:0]   sum_out,
    input logic [N_OUT-1:0]   oe_term,
    input logic               ar_term,
    input logic               ss_term,
    input logic [2*N_OUT-1:0] mc_cfg,
    input logic               lock_q
);

    // R1: the cycle after a reset edge shows an all-intact plane.
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (sum_out == '0 && oe_term == '0 && !ar_term
                           && !ss_term && mc_cfg == '0 && !lock_q));

    // R8: idle configuration is held.
    assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load_en && !cfg_rd_en) |=> ($stable(mc_cfg) && $stable(lock_q)));

    // R9: terms are low while the chain moves.
    assert_busy_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_en || cfg_rd_en) |-> (sum_out == '0 && oe_term == '0
                                        && !ar_term && !ss_term));

    // R7: read-back never alters the lock.
    assert_lock_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_en && !cfg_load_en) |=> $stable(lock_q));

endmodule

bind fuse_sop_plane fuse_sop_plane_chk #(.N_OUT(N_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load_en (cfg_load_en),
    .cfg_rd_en   (cfg_rd_en),
    .sum_out     (sum_out),
    .oe_term     (oe_term),
    .ar_term     (ar_term),
    .ss_term     (ss_term),
    .mc_cfg      (mc_cfg),
    .lock_q      (lock_q)
);

// File: tb/sim_fuse_sop_plane.sv
`timescale 1ns/1ps
module sim_fuse_sop_plane;

    localparam int NI    = 22;
    localparam int NC    = 44;
    localparam int NR    = 132;
    localparam int ARR   = NR * NC;
    localparam int CHAIN = ARR + 20;
    localparam int FUSES = CHAIN + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic        cfg_load_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic        cfg_sdi = 1'b0;
    logic        cfg_sdo;
    logic [9:0]  sum_out;
    logic [9:0]  oe_term;
    logic        ar_term;
    logic        ss_term;
    logic [19:0] mc_cfg;

    logic [FUSES-1:0] img;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fuse_sop_plane u0 (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .cfg_load_en(cfg_load_en), .cfg_rd_en(cfg_rd_en), .cfg_sdi(cfg_sdi),
        .cfg_sdo(cfg_sdo), .sum_out(sum_out), .oe_term(oe_term),
        .ar_term(ar_term), .ss_term(ss_term), .mc_cfg(mc_cfg)
    );

    // Term count per output, rising by two toward the middle.
    function automatic int tb_terms(int o);
        return 8 + 2 * ((o < 5) ? o : 9 - o);
    endfunction

    function automatic int tb_base(int o);
        int b = 1;
        for (int p = 0; p < o; p++) b += tb_terms(p) + 1;
        return b;
    endfunction

    function automatic logic row_val(int r, logic [NI-1:0] v);
        logic t = 1'b1;
        for (int c = 0; c < NC; c++) begin
            logic lit;
            lit = c[0] ? ~v[c/2] : v[c/2];
            if (!img[r*NC + c]) t = t & lit;
        end
        return t;
    endfunction

    // Expected {ar, ss, oe[9:0], sum[9:0]} from the image and input vector.
    function automatic logic [21:0] model(logic [NI-1:0] v);
        logic [9:0] s = '0;
        logic [9:0] e = '0;
        for (int o = 0; o < 10; o++) begin
            int b = tb_base(o);
            e[o] = row_val(b, v);
            for (int j = 1; j <= tb_terms(o); j++) s[o] = s[o] | row_val(b + j, v);
        end
        return {row_val(0, v), row_val(NR - 1, v), e, s};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply a vector mid-cycle and compare without an edge (R10).
    task automatic check_vec(string tag, logic [NI-1:0] v);
        {fb_in, ded_in} = v;
        #1;
        check(tag, {10'd0, ar_term, ss_term, oe_term, sum_out}, {10'd0, model(v)});
        @(negedge clk);
    endtask

    task automatic sweep(string tag);
        logic [NI-1:0] v;
        check_vec(tag, '0);
        check_vec(tag, '1);
        for (int i = 0; i < NI; i++) check_vec(tag, 22'd1 << i);
        for (int i = 0; i < NI; i++) check_vec(tag, ~(22'd1 << i));
        v = 22'h15A3C7;
        for (int i = 0; i < 40; i++) begin
            v = {v[20:0], v[21] ^ v[20]};
            check_vec(tag, v);
        end
    endtask

    task automatic load_img();
        cfg_load_en = 1'b1;
        for (int i = 0; i < FUSES; i++) begin
            cfg_sdi = img[i];
            if (i == 100) begin
                #1;
                check("R9 load gating", {10'd0, ar_term, ss_term, oe_term, sum_out}, 32'd0);
            end
            @(negedge clk);
        end
        cfg_load_en = 1'b0;
        cfg_sdi = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_cmp(string tag, logic locked);
        int bad = 0;
        cfg_rd_en = 1'b1;
        for (int i = 0; i < CHAIN; i++) begin
            logic exp;
            #1;
            exp = locked ? 1'b1 : img[i];
            if (cfg_sdo !== exp) begin
                if (bad == 0) $display("FAIL %s: bit %0d got %b expected %b", tag, i, cfg_sdo, exp);
                bad++;
            end
            if (i == 10) check("R9 read gating", {10'd0, ar_term, ss_term, oe_term, sum_out}, 32'd0);
            @(negedge clk);
        end
        cfg_rd_en = 1'b0;
        n_chk++;
        if (bad != 0) n_fail++;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        img = '0;
        check("R1 sdo", {31'd0, cfg_sdo}, 32'd0);
        check("R1 mc_cfg", {12'd0, mc_cfg}, 32'd0);
        check_vec("R1 zero plane", '0);
        check_vec("R1 zero plane", '1);
        check_vec("R1 zero plane", 22'h2AAAAA);

        // R3: all fuses blown except the lock -> every term 1.
        img = '1;
        img[FUSES-1] = 1'b0;
        load_img();
        sweep("R3 all blown");
        check("R5 mc_cfg all blown", {12'd0, mc_cfg}, {12'd0, 20'hFFFFF});

        // R4/R2: one intact literal per row.
        img = '1;
        for (int r = 0; r < NR; r++) img[r*NC + (r*7 + 3) % NC] = 1'b0;
        img[ARR +: 20] = 20'hA5C3E;
        img[FUSES-1] = 1'b0;
        load_img();
        check_vec("R10 combinational path", 22'h0F0F0F);
        sweep("R4 literal rows");
        check("R5 mc_cfg pattern", {12'd0, mc_cfg}, {12'd0, 20'hA5C3E});
        check("R2 sdo after load", {31'd0, cfg_sdo}, {31'd0, img[0]});
        read_cmp("R6 readback order", 1'b0);
        sweep("R6 restored after read");
        check("R8 mc_cfg held", {12'd0, mc_cfg}, {12'd0, 20'hA5C3E});

        // R4 boundaries: only chosen rows blown.
        img = '0;
        img[0*NC +: NC] = '1;
        img[(NR-1)*NC +: NC] = '1;
        img[tb_base(3)*NC +: NC] = '1;
        img[(tb_base(0) + 8)*NC +: NC] = '1;
        img[(tb_base(1) + 1)*NC +: NC] = '1;
        img[(tb_base(4) + 16)*NC +: NC] = '1;
        load_img();
        {fb_in, ded_in} = 22'h123456;
        #1;
        check("R4 row boundaries", {10'd0, ar_term, ss_term, oe_term, sum_out},
              {10'd0, 1'b1, 1'b1, 10'h008, 10'h013});
        @(negedge clk);
        sweep("R4 boundary sweep");

        // R7: two literals per row, lock blown.
        img = '1;
        for (int r = 0; r < NR; r++) begin
            img[r*NC + (r*5) % NC] = 1'b0;
            img[r*NC + (r*11 + 3) % NC] = 1'b0;
        end
        img[ARR +: 20] = 20'h5A17C;
        img[FUSES-1] = 1'b1;
        load_img();
        check("R7 sdo locked idle", {31'd0, cfg_sdo}, 32'd1);
        read_cmp("R7 locked readback", 1'b1);
        sweep("R7 array under lock");
        check("R5 mc_cfg under lock", {12'd0, mc_cfg}, {12'd0, 20'h5A17C});

        // R1: reset clears lock and fuses.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        img = '0;
        check("R1 lock cleared", {31'd0, cfg_sdo}, 32'd0);
        check_vec("R1 after second reset", 22'h3FFFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule